// File: doc/BRIEF.md
# Flash Query and Identifier Read Responder

This block forms the read word a parallel flash bank returns while it sits in query mode or in identifier mode. The bank is several identical devices placed side by side on the data bus. Each device may run narrower than its widest mode. The block takes the byte address of a read, the bank width, the device width in use, the device's widest width, the access width and the mode. It turns the address into a table index or an identifier select, fetches one byte or code, and spreads the result across the device lanes of the bank. When the access is wider than the bank, it packs several bank-wide responses into one word.

All widths are run-time inputs, counted in bytes, and may be 1, 2 or 4. A command sequencer drives the read strobe. The result is registered on the same clock so that it keeps the sequencer's bus timing. The query table holds the fixed signature and the command-set fields. Every other entry holds one byte chosen by a parameter.

Top module: `flash_query_resp`

## Requirements
- R1: `rdata_o` is 0 after reset. It takes a new value only at a rising edge where `rd_i` is 1, computed from the inputs sampled at that edge. It holds its value at every other edge.
- R2: The index of a response is its byte address shifted right by log2(bank width) + log2(max device width) - log2(device width).
- R3: Query mode (`mode_i` = 0) reads a table with indices 0x00..0x51. Index 0x10 holds 0x51, 0x11 holds 0x52, 0x12 holds 0x59, 0x13 holds 0x01 and 0x14 holds 0x00. Every other index below 0x52 holds the parameter `FILL_BYTE`. Any index of 0x52 or above returns 0.
- R4: In query mode with device width equal to max device width, each device lane carries the table byte in its lowest byte, and the lane's upper bytes are 0.
- R5: In query mode with device width 1 and a wider max device width, every byte of the bank carries the table byte. Device width 2 with max device width 4 returns 0.
- R6: In identifier mode (`mode_i` = 1), only index bits [7:0] are decoded. 0 selects `mfr_code_i`, 1 selects `dev_code_i`, and any other value gives 0. Each device lane carries the low device-width bytes of the selected 16-bit code, zero-extended for 4-byte devices.
- R7: When the access is wider than the bank, chunk k (k = 0, 1, ...) is the bank-wide response for byte address `addr_i` + k*bank width, and it is placed at byte offset k*bank width of `rdata_o`.
- R8: Bytes of `rdata_o` at or above the access width are 0. An access narrower than the bank keeps only the low bytes of the response.
- R9: If any width is not 1, 2 or 4, or the device width exceeds the bank width or the max device width, the read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe; loads the output register |
| mode_i | input | 1 | 0 = query table, 1 = identifier codes |
| addr_i | input | ADDR_W | Byte address of the access |
| bank_w_i | input | 3 | Bank width in bytes |
| dev_w_i | input | 3 | Device width in use, bytes |
| max_w_i | input | 3 | Widest device width, bytes |
| acc_w_i | input | 3 | Access width in bytes |
| mfr_code_i | input | 16 | Manufacturer code |
| dev_code_i | input | 16 | Device code |
| rdata_o | output | 32 | Registered read data |

## Verification
Every result appears exactly one rising edge after the edge that samples `rd_i` high, and it stays in place until the next strobe. The bench sets inputs and raises the strobe on a falling edge, lets one rising edge pass, and reads `rdata_o` on the next falling edge, which is half a cycle after the update. After some reads it changes every input with the strobe low, lets another edge pass, and checks that the output has not moved. The checker's properties use the same one-edge offset through `|=>` and `$past`.

// File: rtl/fqr_pkg.sv
package fqr_pkg;
  localparam int unsigned BUS_BYTES = 4;
  localparam int unsigned WID_W     = 3;

  typedef enum logic {
    MODE_QUERY = 1'b0,
    MODE_IDENT = 1'b1
  } fqr_mode_e;

  function automatic logic width_ok(input logic [WID_W-1:0] w);
    return (w == 3'd1) || (w == 3'd2) || (w == 3'd4);
  endfunction

  function automatic logic [1:0] width_lg(input logic [WID_W-1:0] w);
    case (w)
      3'd2:    return 2'd1;
      3'd4:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/fqr_table.sv
module fqr_table #(
  parameter int unsigned IDX_W     = 16,
  parameter int unsigned DEPTH     = 82,
  parameter logic [7:0]  FILL_BYTE = 8'h00
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       data_o
);
  always_comb begin
    if (idx_i >= IDX_W'(DEPTH)) begin
      data_o = 8'h00;
    end else begin
      case (idx_i)
        IDX_W'(8'h10): data_o = 8'h51;
        IDX_W'(8'h11): data_o = 8'h52;
        IDX_W'(8'h12): data_o = 8'h59;
        IDX_W'(8'h13): data_o = 8'h01;
        IDX_W'(8'h14): data_o = 8'h00;
        default:       data_o = FILL_BYTE;
      endcase
    end
  end
endmodule

// File: rtl/fqr_lane.sv
// One bank-wide response for chunk SLOT of a (possibly wider) access.
module fqr_lane
  import fqr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DEPTH     = 82,
  parameter logic [7:0]  FILL_BYTE = 8'h00,
  parameter int unsigned SLOT      = 0
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   mode_i,
  input  logic [WID_W-1:0]       bank_w_i,
  input  logic [WID_W-1:0]       dev_w_i,
  input  logic [WID_W-1:0]       max_w_i,
  input  logic [15:0]            mfr_code_i,
  input  logic [15:0]            dev_code_i,
  output logic [BUS_BYTES*8-1:0] resp_o
);
  logic [ADDR_W-1:0] slot_addr;
  logic [2:0]        shamt;
  logic [ADDR_W-1:0] idx;
  logic [7:0]        tbl_byte;
  logic [15:0]       code;
  logic [1:0]        dev_mask;

  assign slot_addr = addr_i + (ADDR_W'(SLOT) << width_lg(bank_w_i));
  assign shamt     = {1'b0, width_lg(bank_w_i)} + {1'b0, width_lg(max_w_i)}
                   - {1'b0, width_lg(dev_w_i)};
  assign idx       = slot_addr >> shamt;
  // byte position within a device lane: 1->0, 2->1, 4->3
  assign dev_mask  = dev_w_i[1:0] - 2'd1;

  fqr_table #(
    .IDX_W    (ADDR_W),
    .DEPTH    (DEPTH),
    .FILL_BYTE(FILL_BYTE)
  ) u_table (
    .idx_i (idx),
    .data_o(tbl_byte)
  );

  always_comb begin
    case (idx[7:0])
      8'd0:    code = mfr_code_i;
      8'd1:    code = dev_code_i;
      default: code = 16'h0000;
    endcase
  end

  for (genvar b = 0; b < BUS_BYTES; b++) begin : g_byte
    logic [1:0] pos;
    assign pos = 2'(b) & dev_mask;
    always_comb begin
      if (mode_i == MODE_IDENT) begin
        resp_o[b*8 +: 8] = (pos == 2'd0) ? code[7:0] :
                           (pos == 2'd1) ? code[15:8] : 8'h00;
      end else if (dev_w_i == max_w_i) begin
        resp_o[b*8 +: 8] = (pos == 2'd0) ? tbl_byte : 8'h00;
      end else if (dev_w_i == 3'd1) begin
        resp_o[b*8 +: 8] = tbl_byte;  // narrow mode: repeat, not pad
      end else begin
        resp_o[b*8 +: 8] = 8'h00;
      end
    end
  end
endmodule

// File: rtl/flash_query_resp.sv
module flash_query_resp
  import fqr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DEPTH     = 82,
  parameter logic [7:0]  FILL_BYTE = 8'h00
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rd_i,
  input  logic                   mode_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [2:0]             bank_w_i,
  input  logic [2:0]             dev_w_i,
  input  logic [2:0]             max_w_i,
  input  logic [2:0]             acc_w_i,
  input  logic [15:0]            mfr_code_i,
  input  logic [15:0]            dev_code_i,
  output logic [31:0]            rdata_o
);
  localparam int unsigned DW = BUS_BYTES * 8;

  logic [BUS_BYTES-1:0][DW-1:0] chunk;
  logic [DW-1:0]                word_d;
  logic                         cfg_ok;

  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_slot
    fqr_lane #(
      .ADDR_W   (ADDR_W),
      .DEPTH    (DEPTH),
      .FILL_BYTE(FILL_BYTE),
      .SLOT     (k)
    ) u_lane (
      .addr_i    (addr_i),
      .mode_i    (mode_i),
      .bank_w_i  (bank_w_i),
      .dev_w_i   (dev_w_i),
      .max_w_i   (max_w_i),
      .mfr_code_i(mfr_code_i),
      .dev_code_i(dev_code_i),
      .resp_o    (chunk[k])
    );
  end

  assign cfg_ok = width_ok(bank_w_i) && width_ok(dev_w_i) && width_ok(max_w_i)
               && width_ok(acc_w_i) && (dev_w_i <= bank_w_i) && (dev_w_i <= max_w_i);

  always_comb begin
    logic [1:0] ck;
    logic [1:0] cb;
    word_d = '0;
    for (int p = 0; p < BUS_BYTES; p++) begin
      ck = 2'(p) >> width_lg(bank_w_i);
      cb = 2'(p) & (bank_w_i[1:0] - 2'd1);
      if (cfg_ok && (3'(p) < acc_w_i)) begin
        word_d[p*8 +: 8] = chunk[ck][cb*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      rdata_o <= word_d;
    end
  end
endmodule

// File: rtl/fqr_chk.sv
module fqr_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [2:0]        bank_w_i,
  input logic [2:0]        dev_w_i,
  input logic [2:0]        max_w_i,
  input logic [2:0]        acc_w_i,
  input logic [15:0]       mfr_code_i,
  input logic [31:0]       rdata_o
);
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  assert_tbl_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !mode_i && bank_w_i == 3'd1 && dev_w_i == 3'd1 && max_w_i == 3'd1
    && acc_w_i == 3'd1 && addr_i >= ADDR_W'(8'h52) |=> rdata_o == 32'h0);

  assert_narrow_rep_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !mode_i && bank_w_i == 3'd2 && dev_w_i == 3'd1 && max_w_i == 3'd2
    && acc_w_i == 3'd2 |=> rdata_o[15:8] == rdata_o[7:0]);

  assert_mfr_sel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && mode_i && bank_w_i == 3'd1 && dev_w_i == 3'd1 && max_w_i == 3'd1
    && acc_w_i == 3'd1 && addr_i[7:0] == 8'h00
    |=> rdata_o[7:0] == $past(mfr_code_i[7:0]));

  assert_acc_one_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && acc_w_i == 3'd1 |=> rdata_o[31:8] == 24'h0);

  assert_acc_two_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && acc_w_i == 3'd2 |=> rdata_o[31:16] == 16'h0);

  assert_dev_gt_bank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && dev_w_i > bank_w_i |=> rdata_o == 32'h0);

  assert_odd_bank_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && bank_w_i == 3'd3 |=> rdata_o == 32'h0);
endmodule

bind flash_query_resp fqr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_i      (rd_i),
  .mode_i    (mode_i),
  .addr_i    (addr_i),
  .bank_w_i  (bank_w_i),
  .dev_w_i   (dev_w_i),
  .max_w_i   (max_w_i),
  .acc_w_i   (acc_w_i),
  .mfr_code_i(mfr_code_i),
  .rdata_o   (rdata_o)
);

// File: tb/sim_flash_query_resp.sv
`timescale 1ns/1ps
module sim_flash_query_resp;
  localparam int AW = 16;
  localparam logic [7:0] FILL = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0;
  logic        mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [2:0]  bw = 3'd1, dw = 3'd1, mw = 3'd1, aw = 3'd1;
  logic [15:0] mfr = 16'h0089, devc = 16'h0018;
  logic [31:0] rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_query_resp #(.ADDR_W(AW), .FILL_BYTE(FILL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .mode_i(mode), .addr_i(addr),
    .bank_w_i(bw), .dev_w_i(dw), .max_w_i(mw), .acc_w_i(aw),
    .mfr_code_i(mfr), .dev_code_i(devc), .rdata_o(rdata)
  );

  function automatic int lg(input logic [2:0] w);
    return (w == 3'd4) ? 2 : (w == 3'd2) ? 1 : 0;
  endfunction

  function automatic bit okw(input logic [2:0] w);
    return w == 3'd1 || w == 3'd2 || w == 3'd4;
  endfunction

  function automatic logic [7:0] tbl(input logic [AW-1:0] i);
    if (i >= 16'h52) return 8'h00;
    case (i)
      16'h10: return 8'h51;
      16'h11: return 8'h52;
      16'h12: return 8'h59;
      16'h13: return 8'h01;
      16'h14: return 8'h00;
      default: return FILL;
    endcase
  endfunction

  function automatic logic [31:0] expect_word(
      input logic [AW-1:0] a, input logic md, input logic [2:0] b,
      input logic [2:0] d, input logic [2:0] m, input logic [2:0] ac,
      input logic [15:0] mc, input logic [15:0] dc);
    logic [31:0] r = '0;
    if (!(okw(b) && okw(d) && okw(m) && okw(ac) && d <= b && d <= m)) return '0;
    for (int p = 0; p < 4; p++) begin
      int k, w, q;
      logic [AW-1:0] sa, ix;
      logic [15:0] cd;
      logic [7:0] by;
      if (p >= int'(ac)) continue;
      k  = p / int'(b);
      w  = p % int'(b);
      q  = w % int'(d);
      sa = a + AW'(k * int'(b));
      ix = sa >> (lg(b) + lg(m) - lg(d));
      if (md) begin
        cd = (ix[7:0] == 8'd0) ? mc : (ix[7:0] == 8'd1) ? dc : 16'h0;
        by = (q == 0) ? cd[7:0] : (q == 1) ? cd[15:8] : 8'h00;
      end else if (d == m) begin
        by = (q == 0) ? tbl(ix) : 8'h00;
      end else if (d == 3'd1) begin
        by = tbl(ix);
      end else begin
        by = 8'h00;
      end
      r[p*8 +: 8] = by;
    end
    return r;
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic md, input logic [2:0] b,
      input logic [2:0] d, input logic [2:0] m, input logic [2:0] ac, output logic [31:0] got);
    @(negedge clk);
    addr = a; mode = md; bw = b; dw = d; mw = m; aw = ac; rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
    got = rdata;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic md, input logic [2:0] b,
      input logic [2:0] d, input logic [2:0] m, input logic [2:0] ac, input string req);
    logic [31:0] got;
    do_read(a, md, b, d, m, ac, got);
    check(got, expect_word(a, md, b, d, m, ac, mfr, devc), req);
  endtask

  task automatic lit_chk(input logic [AW-1:0] a, input logic md, input logic [2:0] b,
      input logic [2:0] d, input logic [2:0] m, input logic [2:0] ac,
      input logic [31:0] exp, input string req);
    logic [31:0] got;
    do_read(a, md, b, d, m, ac, got);
    check(got, exp, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  function automatic logic [2:0] pick_w();
    int r = int'($urandom_range(0, 9));
    if (r < 3) return 3'd1;
    if (r < 6) return 3'd2;
    if (r < 9) return 3'd4;
    return 3'($urandom_range(0, 7));
  endfunction

  initial begin
    logic [31:0] got, held;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rdata, 32'h0, "R1 reset");
    rst_n = 1'b1;

    // R3 table signature and bounds
    lit_chk(16'h0010, 1'b0, 3'd1, 3'd1, 3'd1, 3'd1, 32'h51, "R3 Q byte");
    lit_chk(16'h0010, 1'b0, 3'd1, 3'd1, 3'd1, 3'd4, 32'h01595251, "R3 R7 signature packed");
    lit_chk(16'h0051, 1'b0, 3'd1, 3'd1, 3'd1, 3'd1, 32'hA5, "R3 last entry");
    lit_chk(16'h0052, 1'b0, 3'd1, 3'd1, 3'd1, 3'd1, 32'h0, "R3 past end");
    // R2 R4 address scaling, lane padding
    lit_chk(16'h0020, 1'b0, 3'd2, 3'd2, 3'd2, 3'd2, 32'h0051, "R2 R4 bank2 dev2");
    lit_chk(16'h0044, 1'b0, 3'd4, 3'd2, 3'd2, 3'd4, 32'h00520052, "R2 R4 two lanes");
    lit_chk(16'h0048, 1'b0, 3'd4, 3'd4, 3'd4, 3'd4, 32'h00000059, "R4 wide device");
    // R5 narrow-mode repeat
    lit_chk(16'h0048, 1'b0, 3'd2, 3'd1, 3'd2, 3'd2, 32'h5959, "R5 repeat");
    lit_chk(16'h0024, 1'b0, 3'd2, 3'd1, 3'd2, 3'd2, 32'hA5A5, "R2 R5 fill repeat");
    lit_chk(16'h0080, 1'b0, 3'd4, 3'd2, 3'd4, 3'd4, 32'h0, "R5 unsupported narrow");
    // R6 identifier
    mfr = 16'h1289; devc = 16'h3418;
    lit_chk(16'h0000, 1'b1, 3'd1, 3'd1, 3'd1, 3'd1, 32'h89, "R6 manufacturer");
    lit_chk(16'h0100, 1'b1, 3'd1, 3'd1, 3'd1, 3'd1, 32'h89, "R6 low 8 bits only");
    lit_chk(16'h0002, 1'b1, 3'd1, 3'd1, 3'd1, 3'd1, 32'h0, "R6 other index");
    lit_chk(16'h0000, 1'b1, 3'd1, 3'd1, 3'd1, 3'd2, 32'h1889, "R6 R7 packed codes");
    lit_chk(16'h0004, 1'b1, 3'd4, 3'd4, 3'd4, 3'd4, 32'h00003418, "R6 four-byte device");
    lit_chk(16'h0000, 1'b1, 3'd4, 3'd2, 3'd2, 3'd4, 32'h12891289, "R6 two lanes");
    // R8 truncation, R9 illegal
    lit_chk(16'h0000, 1'b1, 3'd4, 3'd2, 3'd2, 3'd1, 32'h89, "R8 narrow access");
    lit_chk(16'h0010, 1'b0, 3'd3, 3'd1, 3'd1, 3'd1, 32'h0, "R9 bank 3");
    lit_chk(16'h0010, 1'b0, 3'd1, 3'd2, 3'd2, 3'd1, 32'h0, "R9 dev over bank");
    lit_chk(16'h0010, 1'b0, 3'd1, 3'd1, 3'd1, 3'd0, 32'h0, "R9 access 0");

    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      logic md;
      logic [2:0] b, d, m, ac;
      mfr  = 16'($urandom);
      devc = 16'($urandom);
      md   = 1'($urandom_range(0, 1));
      b = pick_w(); d = pick_w(); m = pick_w(); ac = pick_w();
      a = ($urandom_range(0, 3) == 0) ? AW'($urandom) : AW'($urandom_range(0, 16'h160));
      rd_chk(a, md, b, d, m, ac, "R2 R3 R4 R5 R6 R7 R8 R9 random");
      if (i % 8 == 0) begin
        held = rdata;
        @(negedge clk);
        addr = AW'($urandom); mode = ~mode; bw = pick_w(); aw = pick_w();
        mfr = 16'($urandom);
        @(posedge clk);
        @(negedge clk);
        check(rdata, held, "R1 hold without strobe");
      end
    end
    got = '0;
    finish_run();
  end
endmodule